// File: doc/BRIEF.md
# Structured Test Image Generator

This block produces one grayscale test image for the self-test of a neural-network accelerator. The image is sent as a raster pixel stream with a valid/ready handshake. A pulse on `start_i` loads a 32-bit seed and asks for a given number of chosen rows and chosen columns. The block first draws the lines from a pseudorandom source and stores them. It then streams the whole image, row by row, with the column index advancing fastest.

Each chosen line gets one of three two-pixel primitives and one signed intensity `f`. The primitive repeats along the whole line. Where a chosen row crosses a chosen column, the column's value wins. Every pixel that lies on no chosen line is zero. The intensity imitates a zero-centred sample with unit spread. It is formed by summing four 6-bit fields of the random state, removing their mean, scaling by 1.75 and saturating. The result is a Q1.6 value, so 64 stands for 1.0.

Top module: `stig_gen`

## Requirements
- R1: While reset is held and right after its release, `pix_valid_o` and `done_o` are low.
- R2: A run streams exactly IMG_H×IMG_W pixels in row-major order. `pix_row_o` and `pix_col_o` give the position of the pixel on offer. `done_o` is high for one cycle, in the cycle after the last pixel is accepted.
- R3: While `pix_valid_o` is high and `pix_ready_i` is low, the pixel value and both indices stay unchanged and valid stays high.
- R4: Exactly min(`rows_i`, IMG_H) distinct rows and min(`cols_i`, IMG_W) distinct columns are chosen. Counts above the image size are clamped, so such a request gives the same image as a request for the full size.
- R5: Primitive code 0 puts 0 on the even position and f on the odd position. Code 1 puts f on the even position and 0 on the odd position. Code 2 puts f on both. Positions are column parity along a row and row parity down a column. Code 3 is never used: it is redrawn. All three codes occur.
- R6: A pixel on both a chosen row and a chosen column carries the column's primitive value.
- R7: A pixel on no chosen line is zero. With both counts at zero, the whole image is zero.
- R8: `f` is a signed 8-bit Q1.6 value and is never zero: a zero draw is redrawn. Over many lines its mean lies within ±0.25, more than 55% of values lie within ±1.0 (±64), and some lie beyond that.
- R9: Draws come from a 32-bit Galois LFSR with tap mask 0x80200003, loaded with the seed. A zero seed is replaced by 1. The same seed and counts always give the same image, whatever the stall pattern.
- R10: A start request that arrives while lines are being drawn or pixels streamed is ignored and does not disturb the image in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a new image when idle |
| seed_i | input | 32 | LFSR seed taken with the request |
| rows_i | input | CNT_W | Number of rows to choose |
| cols_i | input | CNT_W | Number of columns to choose |
| pix_ready_i | input | 1 | Sink accepts the pixel on offer |
| pix_valid_o | output | 1 | A pixel is on offer |
| pix_data_o | output | 8 | Signed Q1.6 pixel value |
| pix_row_o | output | clog2(IMG_H) | Row of the pixel on offer |
| pix_col_o | output | clog2(IMG_W) | Column of the pixel on offer |
| done_o | output | 1 | One-cycle pulse after the last pixel |

## Verification
The line tables are filled during the drawing phase and read only during streaming. A fault in them, such as a lost selection bit, a duplicate index or a wrong primitive code, first shows up in the pixel stream of the same run. The bench catches it on the first affected line. It rebuilds the chosen rows and columns from the received image and compares their number and shape with the request. A broken raster counter or handshake shows at once in the pixel indices, or in the held values during a stall. An error in the intensity shaping shows only over many lines, as a shifted mean or spread, so the bench gathers every intensity over the whole sweep.

// File: rtl/stig_pkg.sv
package stig_pkg;

    localparam int PIX_W  = 8;
    localparam int LFSR_W = 32;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 32'h8020_0003;
    localparam logic [LFSR_W-1:0] LFSR_ALT  = 32'h0000_0001;

    typedef enum logic [1:0] {
        PRIM_ZF  = 2'd0,
        PRIM_FZ  = 2'd1,
        PRIM_FF  = 2'd2,
        PRIM_BAD = 2'd3
    } prim_e;

    typedef enum logic [1:0] {
        PK_IDLE = 2'd0,
        PK_ROWS = 2'd1,
        PK_COLS = 2'd2
    } pick_st_e;

    typedef enum logic {
        RS_IDLE   = 1'b0,
        RS_STREAM = 1'b1
    } ras_st_e;

    // value of one pixel of a pair primitive; odd selects the neighbour position
    function automatic logic [PIX_W-1:0] prim_pixel(input logic [1:0] code,
                                                    input logic [PIX_W-1:0] f,
                                                    input logic odd);
        logic [PIX_W-1:0] v;
        case (prim_e'(code))
            PRIM_ZF: v = odd ? f : '0;
            PRIM_FZ: v = odd ? '0 : f;
            PRIM_FF: v = f;
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/stig_lfsr.sv
module stig_lfsr
    import stig_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [LFSR_W-1:0] seed_i,
    input  logic              step_i,
    output logic [LFSR_W-1:0] state_o
);

    logic [LFSR_W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = lfsr_q;
        if (load_i) begin
            lfsr_d = (seed_i == '0) ? LFSR_ALT : seed_i;
        end else if (step_i) begin
            lfsr_d = lfsr_q[0] ? ((lfsr_q >> 1) ^ LFSR_TAPS) : (lfsr_q >> 1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) lfsr_q <= LFSR_ALT;
        else         lfsr_q <= lfsr_d;
    end

    assign state_o = lfsr_q;

    AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lfsr_q != '0); // R9

endmodule

// File: rtl/stig_fshape.sv
module stig_fshape
    import stig_pkg::*;
#(
    parameter int FW = 6,
    parameter int NF = 4
) (
    input  logic [FW*NF-1:0] raw_i,
    output logic [PIX_W-1:0] f_o
);

    localparam int SUM_W = FW + $clog2(NF);
    localparam int DW    = SUM_W + 3;
    localparam int MEAN  = NF * ((1 << FW) - 1) / 2;
    localparam logic signed [DW-1:0] MEAN_S = DW'(MEAN);
    localparam logic signed [DW-1:0] F_MAX  = DW'((1 << (PIX_W - 1)) - 1);
    localparam logic signed [DW-1:0] F_MIN  = -F_MAX - DW'(1);

    logic [SUM_W-1:0]     sum;
    logic signed [DW-1:0] dev;
    logic signed [DW-1:0] scl;

    always_comb begin
        sum = '0;
        for (int k = 0; k < NF; k++) begin
            sum = sum + SUM_W'(raw_i[k*FW +: FW]);
        end
        dev = $signed(DW'(sum)) - MEAN_S;
        // scale by 1.75 to bring the spread close to one Q1.6 unit
        scl = dev + (dev >>> 1) + (dev >>> 2);
        if (scl > F_MAX)      f_o = F_MAX[PIX_W-1:0];
        else if (scl < F_MIN) f_o = F_MIN[PIX_W-1:0];
        else                  f_o = scl[PIX_W-1:0];
    end

endmodule

// File: rtl/stig_picker.sv
module stig_picker
    import stig_pkg::*;
#(
    parameter int H     = 28,
    parameter int W     = 28,
    parameter int CNT_W = 8,
    parameter int CODE_LSB = 16
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      start_i,
    input  logic [CNT_W-1:0]          rows_i,
    input  logic [CNT_W-1:0]          cols_i,
    input  logic [LFSR_W-1:0]         lfsr_i,
    input  logic [PIX_W-1:0]          f_i,
    output logic                      load_o,
    output logic                      step_o,
    output logic                      busy_o,
    output logic                      go_o,
    output logic [H-1:0]              rsel_o,
    output logic [H-1:0][1:0]         rcode_o,
    output logic [H-1:0][PIX_W-1:0]   rf_o,
    output logic [W-1:0]              csel_o,
    output logic [W-1:0][1:0]         ccode_o,
    output logic [W-1:0][PIX_W-1:0]   cf_o
);

    localparam int RW = $clog2(H);
    localparam int CW = $clog2(W);
    localparam logic [CNT_W-1:0] H_CNT = CNT_W'(H);
    localparam logic [CNT_W-1:0] W_CNT = CNT_W'(W);
    localparam logic [RW:0]      H_LIM = (RW+1)'(H);
    localparam logic [CW:0]      W_LIM = (CW+1)'(W);

    typedef struct packed {
        pick_st_e                 st;
        logic                     phase;
        logic [CNT_W-1:0]         need_r;
        logic [CNT_W-1:0]         need_c;
        logic [CNT_W-1:0]         got;
        logic [RW-1:0]            cand_r;
        logic [CW-1:0]            cand_c;
        logic [1:0]               code;
        logic [H-1:0]             rsel;
        logic [H-1:0][1:0]        rcode;
        logic [H-1:0][PIX_W-1:0]  rf;
        logic [W-1:0]             csel;
        logic [W-1:0][1:0]        ccode;
        logic [W-1:0][PIX_W-1:0]  cf;
    } pick_t;

    pick_t pick_d, pick_q;

    logic [RW-1:0] draw_r;
    logic [CW-1:0] draw_c;
    logic [1:0]    draw_code;
    logic          row_ok, col_ok, code_ok;

    assign draw_r    = lfsr_i[RW-1:0];
    assign draw_c    = lfsr_i[CW-1:0];
    assign draw_code = lfsr_i[CODE_LSB +: 2];
    assign code_ok   = (prim_e'(draw_code) != PRIM_BAD);
    assign row_ok    = ({1'b0, draw_r} < H_LIM) && !pick_q.rsel[draw_r] && code_ok;
    assign col_ok    = ({1'b0, draw_c} < W_LIM) && !pick_q.csel[draw_c] && code_ok;

    always_comb begin
        pick_d = pick_q;
        load_o = 1'b0;
        go_o   = 1'b0;
        case (pick_q.st)
            PK_IDLE: begin
                if (start_i) begin
                    load_o        = 1'b1;
                    pick_d.st     = PK_ROWS;
                    pick_d.phase  = 1'b0;
                    pick_d.got    = '0;
                    pick_d.need_r = (rows_i > H_CNT) ? H_CNT : rows_i;
                    pick_d.need_c = (cols_i > W_CNT) ? W_CNT : cols_i;
                    pick_d.rsel   = '0;
                    pick_d.rcode  = '0;
                    pick_d.rf     = '0;
                    pick_d.csel   = '0;
                    pick_d.ccode  = '0;
                    pick_d.cf     = '0;
                end
            end
            PK_ROWS: begin
                if (pick_q.got == pick_q.need_r) begin
                    pick_d.st    = PK_COLS;
                    pick_d.got   = '0;
                    pick_d.phase = 1'b0;
                end else if (!pick_q.phase) begin
                    if (row_ok) begin
                        pick_d.cand_r = draw_r;
                        pick_d.code   = draw_code;
                        pick_d.phase  = 1'b1;
                    end
                end else if (f_i != '0) begin
                    pick_d.rsel[pick_q.cand_r]  = 1'b1;
                    pick_d.rcode[pick_q.cand_r] = pick_q.code;
                    pick_d.rf[pick_q.cand_r]    = f_i;
                    pick_d.got                  = pick_q.got + CNT_W'(1);
                    pick_d.phase                = 1'b0;
                end
            end
            PK_COLS: begin
                if (pick_q.got == pick_q.need_c) begin
                    go_o         = 1'b1;
                    pick_d.st    = PK_IDLE;
                    pick_d.phase = 1'b0;
                end else if (!pick_q.phase) begin
                    if (col_ok) begin
                        pick_d.cand_c = draw_c;
                        pick_d.code   = draw_code;
                        pick_d.phase  = 1'b1;
                    end
                end else if (f_i != '0) begin
                    pick_d.csel[pick_q.cand_c]  = 1'b1;
                    pick_d.ccode[pick_q.cand_c] = pick_q.code;
                    pick_d.cf[pick_q.cand_c]    = f_i;
                    pick_d.got                  = pick_q.got + CNT_W'(1);
                    pick_d.phase                = 1'b0;
                end
            end
            default: pick_d.st = PK_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) pick_q <= '0;
        else         pick_q <= pick_d;
    end

    assign step_o  = (pick_q.st != PK_IDLE);
    assign busy_o  = (pick_q.st != PK_IDLE);
    assign rsel_o  = pick_q.rsel;
    assign rcode_o = pick_q.rcode;
    assign rf_o    = pick_q.rf;
    assign csel_o  = pick_q.csel;
    assign ccode_o = pick_q.ccode;
    assign cf_o    = pick_q.cf;

    AST_ROW_TALLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pick_q.st == PK_ROWS) |-> ($countones(pick_q.rsel) == int'(pick_q.got))); // R4
    AST_COL_TALLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pick_q.st == PK_COLS) |-> ($countones(pick_q.csel) == int'(pick_q.got))); // R4
    AST_GO_COUNTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        go_o |-> ($countones(pick_q.rsel) == int'(pick_q.need_r)
                  && $countones(pick_q.csel) == int'(pick_q.need_c))); // R4
    AST_NO_CODE3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pick_q.st != PK_IDLE && pick_q.phase) |-> (prim_e'(pick_q.code) != PRIM_BAD)); // R5

endmodule

// File: rtl/stig_raster.sv
module stig_raster
    import stig_pkg::*;
#(
    parameter int H = 28,
    parameter int W = 28
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     go_i,
    input  logic                     ready_i,
    input  logic [H-1:0]             rsel_i,
    input  logic [H-1:0][1:0]        rcode_i,
    input  logic [H-1:0][PIX_W-1:0]  rf_i,
    input  logic [W-1:0]             csel_i,
    input  logic [W-1:0][1:0]        ccode_i,
    input  logic [W-1:0][PIX_W-1:0]  cf_i,
    output logic                     valid_o,
    output logic [$clog2(H)-1:0]     row_o,
    output logic [$clog2(W)-1:0]     col_o,
    output logic [PIX_W-1:0]         pix_o,
    output logic                     done_o,
    output logic                     active_o
);

    localparam int RW = $clog2(H);
    localparam int CW = $clog2(W);
    localparam logic [RW-1:0] ROW_LAST = RW'(H - 1);
    localparam logic [CW-1:0] COL_LAST = CW'(W - 1);

    typedef struct packed {
        ras_st_e       st;
        logic [RW-1:0] row;
        logic [CW-1:0] col;
        logic          done;
    } ras_t;

    ras_t ras_d, ras_q;

    always_comb begin
        ras_d      = ras_q;
        ras_d.done = 1'b0;
        case (ras_q.st)
            RS_IDLE: begin
                if (go_i) begin
                    ras_d.st  = RS_STREAM;
                    ras_d.row = '0;
                    ras_d.col = '0;
                end
            end
            RS_STREAM: begin
                if (ready_i) begin
                    if (ras_q.col == COL_LAST) begin
                        ras_d.col = '0;
                        if (ras_q.row == ROW_LAST) begin
                            ras_d.st   = RS_IDLE;
                            ras_d.done = 1'b1;
                        end else begin
                            ras_d.row = ras_q.row + RW'(1);
                        end
                    end else begin
                        ras_d.col = ras_q.col + CW'(1);
                    end
                end
            end
            default: ras_d.st = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) ras_q <= '0;
        else         ras_q <= ras_d;
    end

    // column content overrides row content at a crossing
    always_comb begin
        if (csel_i[ras_q.col]) begin
            pix_o = prim_pixel(ccode_i[ras_q.col], cf_i[ras_q.col], ras_q.row[0]);
        end else if (rsel_i[ras_q.row]) begin
            pix_o = prim_pixel(rcode_i[ras_q.row], rf_i[ras_q.row], ras_q.col[0]);
        end else begin
            pix_o = '0;
        end
    end

    assign valid_o  = (ras_q.st == RS_STREAM);
    assign active_o = (ras_q.st == RS_STREAM);
    assign row_o    = ras_q.row;
    assign col_o    = ras_q.col;
    assign done_o   = ras_q.done;

    AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && !ready_i) |=> (valid_o && $stable(row_o) && $stable(col_o) && $stable(pix_o))); // R3
    AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> $past(valid_o && ready_i && row_o == ROW_LAST && col_o == COL_LAST)); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R2
    AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> ({1'b0, row_o} < (RW+1)'(H) && {1'b0, col_o} < (CW+1)'(W))); // R2

endmodule

// File: rtl/stig_gen.sv
module stig_gen
    import stig_pkg::*;
#(
    parameter int IMG_H = 28,
    parameter int IMG_W = 28,
    parameter int CNT_W = 8
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       start_i,
    input  logic [31:0]                seed_i,
    input  logic [CNT_W-1:0]           rows_i,
    input  logic [CNT_W-1:0]           cols_i,
    input  logic                       pix_ready_i,
    output logic                       pix_valid_o,
    output logic [7:0]                 pix_data_o,
    output logic [$clog2(IMG_H)-1:0]   pix_row_o,
    output logic [$clog2(IMG_W)-1:0]   pix_col_o,
    output logic                       done_o
);

    localparam int F_FIELD = 6;
    localparam int F_TERMS = 4;
    localparam int F_LSB   = LFSR_W - F_FIELD * F_TERMS;

    logic                          pick_busy, stream_active, start_ok;
    logic                          lfsr_load, lfsr_step, go;
    logic [LFSR_W-1:0]             lfsr_state;
    logic [PIX_W-1:0]              f_val;
    logic [IMG_H-1:0]              rsel;
    logic [IMG_H-1:0][1:0]         rcode;
    logic [IMG_H-1:0][PIX_W-1:0]   rf;
    logic [IMG_W-1:0]              csel;
    logic [IMG_W-1:0][1:0]         ccode;
    logic [IMG_W-1:0][PIX_W-1:0]   cf;

    assign start_ok = start_i && !pick_busy && !stream_active;

    stig_lfsr i_lfsr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (lfsr_load),
        .seed_i  (seed_i),
        .step_i  (lfsr_step),
        .state_o (lfsr_state)
    );

    stig_fshape #(.FW(F_FIELD), .NF(F_TERMS)) i_fshape (
        .raw_i (lfsr_state[LFSR_W-1:F_LSB]),
        .f_o   (f_val)
    );

    stig_picker #(.H(IMG_H), .W(IMG_W), .CNT_W(CNT_W)) i_picker (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_ok),
        .rows_i  (rows_i),
        .cols_i  (cols_i),
        .lfsr_i  (lfsr_state),
        .f_i     (f_val),
        .load_o  (lfsr_load),
        .step_o  (lfsr_step),
        .busy_o  (pick_busy),
        .go_o    (go),
        .rsel_o  (rsel),
        .rcode_o (rcode),
        .rf_o    (rf),
        .csel_o  (csel),
        .ccode_o (ccode),
        .cf_o    (cf)
    );

    stig_raster #(.H(IMG_H), .W(IMG_W)) i_raster (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .go_i     (go),
        .ready_i  (pix_ready_i),
        .rsel_i   (rsel),
        .rcode_i  (rcode),
        .rf_i     (rf),
        .csel_i   (csel),
        .ccode_i  (ccode),
        .cf_i     (cf),
        .valid_o  (pix_valid_o),
        .row_o    (pix_row_o),
        .col_o    (pix_col_o),
        .pix_o    (pix_data_o),
        .done_o   (done_o),
        .active_o (stream_active)
    );

    AST_PHASES_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(pick_busy && stream_active)); // R10
    AST_TABLES_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stream_active && $past(stream_active)) |-> ($stable(rsel) && $stable(csel))); // R10

endmodule

// File: tb/test_stig_gen.sv
module test_stig_gen;

    localparam int H = 8;
    localparam int W = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [31:0] seed = '0;
    logic [7:0] rows = '0;
    logic [7:0] cols = '0;
    logic       ready = 1'b1;
    logic       valid;
    logic [7:0] data;
    logic [2:0] prow;
    logic [2:0] pcol;
    logic       done;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    logic [7:0] img    [H][W];
    logic [7:0] refimg [H][W];

    int st_sum = 0, st_cnt = 0, st_in = 0, st_out = 0;
    int seen [3] = '{0, 0, 0};

    always #5 clk = ~clk;

    stig_gen #(.IMG_H(H), .IMG_W(W), .CNT_W(8)) i_stig_gen (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .start_i     (start),
        .seed_i      (seed),
        .rows_i      (rows),
        .cols_i      (cols),
        .pix_ready_i (ready),
        .pix_valid_o (valid),
        .pix_data_o  (data),
        .pix_row_o   (prow),
        .pix_col_o   (pcol),
        .done_o      (done)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] b_prim(input int k, input logic [7:0] f, input bit odd);
        if (k == 0) return odd ? f : 8'd0;
        if (k == 1) return odd ? 8'd0 : f;
        return f;
    endfunction

    // does v match one primitive with one nonzero f at the positions in use[]
    function automatic bit fit_masked(input logic [7:0] v [8], input bit use_p [8],
                                      output int code, output logic [7:0] f);
        bit ok;
        f = 8'd0;
        code = -1;
        for (int i = 0; i < 8; i++) if (use_p[i] && f == 8'd0 && v[i] != 8'd0) f = v[i];
        if (f == 8'd0) return 1'b0;
        for (int k = 0; k < 3; k++) begin
            ok = 1'b1;
            for (int i = 0; i < 8; i++)
                if (use_p[i] && v[i] != b_prim(k, f, i[0])) ok = 1'b0;
            if (ok) begin
                code = k;
                return 1'b1;
            end
        end
        return 1'b0;
    endfunction

    task automatic rec(input int k, input logic [7:0] f);
        int fs;
        fs = int'($signed(f));
        st_sum += fs;
        st_cnt++;
        if (fs <= 64 && fs >= -64) st_in++;
        else st_out++;
        if (k >= 0 && k < 3) seen[k]++;
    endtask

    task automatic run_image(input logic [31:0] s, input int m, input int n,
                             input bit stall, input int intr_at);
        int idx = 0;
        int t = 0;
        bit prev_stall = 1'b0;
        bit intrd = 1'b0;
        logic [7:0] pd = '0;
        logic [2:0] pr = '0, pc = '0;
        @(negedge clk);
        start = 1'b1; seed = s; rows = 8'(m); cols = 8'(n); ready = 1'b1;
        while (idx < H * W && t < 20000) begin
            @(negedge clk);
            t++;
            if (intr_at >= 0 && !intrd && idx >= intr_at && t > 1) begin
                start = 1'b1; seed = ~s; rows = 8'd3; cols = 8'd2; intrd = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (prev_stall)
                chk(valid && data == pd && prow == pr && pcol == pc, "R3", "held pixel",
                    int'(data), int'(pd));
            ready = stall ? ((t % 3) != 0) : 1'b1;
            if (valid) begin
                if (ready) begin
                    chk(int'(prow) == idx / W && int'(pcol) == idx % W, "R2", "raster index",
                        int'(prow) * W + int'(pcol), idx);
                    img[idx / W][idx % W] = data;
                    idx++;
                end
            end
            prev_stall = valid && !ready;
            pd = data; pr = prow; pc = pcol;
        end
        chk(idx == H * W, "R2", "pixel count", idx, H * W);
        @(negedge clk);
        start = 1'b0; ready = 1'b1;
        chk(done == 1'b1, "R2", "done after last", int'(done), 1);
        @(negedge clk);
        chk(done == 1'b0, "R2", "done one cycle", int'(done), 0);
    endtask

    task automatic save_ref();
        for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) refimg[r][c] = img[r][c];
    endtask

    task automatic cmp_ref(input string req, input string what);
        int diff = 0;
        for (int r = 0; r < H; r++) for (int c = 0; c < W; c++)
            if (refimg[r][c] !== img[r][c]) diff++;
        chk(diff == 0, req, what, diff, 0);
    endtask

    task automatic analyze(input int m, input int n);
        bit colc [8];
        bit rowc [8];
        int cc [8];
        logic [7:0] cfv [8];
        logic [7:0] v [8];
        bit use_p [8];
        int nc = 0, nr = 0, badrow = 0, badx = 0, code;
        logic [7:0] f;
        for (int i = 0; i < 8; i++) use_p[i] = 1'b1;
        for (int c = 0; c < W; c++) begin
            for (int r = 0; r < H; r++) v[r] = img[r][c];
            colc[c] = fit_masked(v, use_p, cc[c], cfv[c]);
            if (colc[c]) begin
                nc++;
                rec(cc[c], cfv[c]);
            end
        end
        for (int r = 0; r < H; r++) begin
            rowc[r] = 1'b0;
            for (int c = 0; c < W; c++) begin
                v[c] = img[r][c];
                use_p[c] = !colc[c];
                if (!colc[c] && img[r][c] != 8'd0) rowc[r] = 1'b1;
            end
            if (rowc[r]) begin
                nr++;
                if (fit_masked(v, use_p, code, f)) rec(code, f);
                else badrow++;
                for (int c = 0; c < W; c++)
                    if (colc[c] && img[r][c] != b_prim(cc[c], cfv[c], r[0])) badx++;
            end
        end
        chk(nc == n, "R4", "distinct columns", nc, n);
        chk(nr == m, "R4", "distinct rows", nr, m);
        chk(badrow == 0, "R5", "row primitive shape", badrow, 0);
        chk(badx == 0, "R6", "crossing takes column", badx, 0);
    endtask

    task automatic full_lines(input bit by_col, input string what);
        logic [7:0] v [8];
        bit use_p [8];
        int good = 0, code;
        logic [7:0] f;
        for (int i = 0; i < 8; i++) use_p[i] = 1'b1;
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) v[b] = by_col ? img[b][a] : img[a][b];
            if (fit_masked(v, use_p, code, f)) begin
                good++;
                rec(code, f);
            end
        end
        chk(good == 8, "R5", what, good, 8);
    endtask

    initial begin
        int zeros;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(valid == 1'b0 && done == 1'b0, "R1", "idle in reset", int'(valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(valid == 1'b0 && done == 1'b0, "R1", "idle after reset", int'(valid), 0);

        // R7 empty image
        run_image(32'h1234_5678, 0, 0, 1'b0, -1);
        zeros = 0;
        for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) if (img[r][c] == 8'd0) zeros++;
        chk(zeros == H * W, "R7", "empty image zero", zeros, H * W);

        // sweep of seeds and counts
        for (int k = 1; k <= 6; k++)
            for (int m = 0; m <= 3; m++)
                for (int n = 0; n <= 3; n++) begin
                    run_image(32'(k * 32'h9E37_79B1 + 32'd13), m, n, 1'b0, -1);
                    analyze(m, n);
                end

        // R4 clamp and full rows / columns
        run_image(32'hCAFE_0001, 8, 0, 1'b0, -1);
        full_lines(1'b0, "every row chosen");
        save_ref();
        run_image(32'hCAFE_0001, 200, 0, 1'b0, -1);
        cmp_ref("R4", "row count clamp");
        run_image(32'hBEEF_0002, 0, 8, 1'b0, -1);
        full_lines(1'b1, "every column chosen");
        save_ref();
        run_image(32'hBEEF_0002, 0, 255, 1'b0, -1);
        cmp_ref("R4", "column count clamp");

        // R9 reproducibility, R3 stalls
        run_image(32'h0BAD_F00D, 3, 2, 1'b0, -1);
        save_ref();
        run_image(32'h0BAD_F00D, 3, 2, 1'b1, -1);
        cmp_ref("R9", "same seed with stalls");

        // R10 start ignored while busy
        run_image(32'h0BAD_F00D, 3, 2, 1'b0, 20);
        cmp_ref("R10", "start during stream");
        run_image(32'h0BAD_F00D, 3, 2, 1'b0, 0);
        cmp_ref("R10", "start during drawing");

        // R9 zero seed behaves as seed 1
        run_image(32'h0000_0001, 2, 3, 1'b0, -1);
        save_ref();
        run_image(32'h0000_0000, 2, 3, 1'b0, -1);
        cmp_ref("R9", "zero seed replaced");

        // R8 intensity statistics, R5 code usage
        chk(st_cnt > 100, "R8", "lines gathered", st_cnt, 100);
        chk(st_sum * 4 <= st_cnt * 64 && st_sum * 4 >= -st_cnt * 64, "R8", "mean x cnt",
            st_sum, 0);
        chk(st_in * 100 > st_cnt * 55, "R8", "share within one", st_in, st_cnt);
        chk(st_out > 0, "R8", "values beyond one", st_out, 1);
        chk(seen[0] > 0 && seen[1] > 0 && seen[2] > 0, "R5", "all codes used",
            seen[0] * 10000 + seen[1] * 100 + seen[2], 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule